// File: doc/BRIEF.md
# Converter Reset and Synchronisation Sequencer

This block brings a high-speed data converter out of reset in a fixed, repeatable order. It drives four control lines toward the converter. The first is the data-ready reset, whose active level is set by a configuration input. The second is the demultiplexer reset, which is always active high. The third is the serial-interface reset. The fourth is an enable for the converter's sample-clock gate. A one-cycle start pulse begins a run. A mode input, sampled at that start, picks one of two orderings.

The free-running ordering leaves the sample clock on and nests the demultiplexer reset pulse inside the data-ready reset pulse. It suits a single converter. The synchronised ordering suits several converters that must start on the same edge. It first lets the sample clock run for a set number of warm-up cycles, then holds the clock low, then applies the same nested pulses. It switches the clock back on only once the data-ready reset has been released.

A busy flag covers the whole run. A done flag then marks the point from which the converter's registers may be programmed. All pulse widths and the warm-up length are parameters counted in system clock cycles.

Top module: `convResetSeq`

## Requirements
- R1: After reset the block is idle with busy=0, done=0, demuxRst=0, serialRst=0, clkEn=1, and drrOut at the inactive level of the polarity input.
- R2: A start pulse seen in idle or done state begins a run. busy is 1 from the start edge until the edge that sets done, and it is never 1 together with done. done stays 1 until the next accepted start.
- R3: demuxRst is asserted only while the data-ready reset is active. It rises LEAD_CYC cycles after the data-ready reset becomes active, and it is released at least one cycle before the data-ready reset is released.
- R4: demuxRst stays high for exactly ARST_CYC cycles. The data-ready reset stays active for LEAD_CYC+ARST_CYC+tail cycles, where tail = max(1, DRR_MIN_CYC-LEAD_CYC-ARST_CYC), so the pulse is never shorter than DRR_MIN_CYC.
- R5: When drrActHigh=1, drrOut is 1 while the data-ready reset is active. When drrActHigh=0, drrOut is 0 while it is active. The polarity is taken at the start edge and held for the whole run. In idle or done state drrOut follows the polarity input one cycle later.
- R6: serialRst is high in exactly the same cycles as the data-ready reset.
- R7: With modeSync=0 at start, the data-ready reset becomes active on the start edge, clkEn stays 1 for the whole run, and done rises LEAD_CYC+ARST_CYC+tail+1 cycles after start.
- R8: With modeSync=1 at start, clkEn falls WARM_CYC cycles after start. The data-ready reset becomes active one cycle after that. clkEn returns to 1 on the edge that releases the data-ready reset, and done follows one cycle later.
- R9: clkEn changes only on the falling clock edge, while the gated clock is low, and never while the clock is high.
- R10: done rises one cycle after the data-ready reset is released, at a point where demuxRst=0 and clkEn=1.
- R11: Start pulses and changes of modeSync or drrActHigh that arrive while busy=1 do not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle or done |
| modeSync | input | 1 | 0 selects the free-running order, 1 selects the synchronised order |
| drrActHigh | input | 1 | Active level of the data-ready reset: 1 high, 0 low |
| drrOut | output | 1 | Data-ready reset toward the converter |
| demuxRst | output | 1 | Demultiplexer reset, active high |
| serialRst | output | 1 | Serial-interface reset, active high |
| clkEn | output | 1 | Sample-clock gate enable, changes on the falling edge |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run complete, register programming allowed |

## Verification
Counting from the edge that accepts start as cycle 0, the data-ready and serial resets change on that edge in the free-running order. In the synchronised order they change WARM_CYC+1 edges later. The demultiplexer reset follows LEAD_CYC edges after the data-ready reset, busy changes on edge 0, and done arrives on the edge after the data-ready reset is released. clkEn moves on the falling edge just after the edge that requests the change. The driver queues one expected output word per cycle, indexed from the start edge. The monitor takes one word from the queue a quarter period after each falling edge, when all registered outputs and the falling-edge enable have settled. A second sample, a quarter period after each rising edge, confirms that clkEn never moves on the rising edge.

// File: rtl/convSeqPkg.sv
package convSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_STOP,
    ST_LEAD,
    ST_PULSE,
    ST_TAIL,
    ST_SETTLE,
    ST_DONE
  } seqState_t;

  typedef enum logic [1:0] {
    LD_WARM,
    LD_LEAD,
    LD_PULSE,
    LD_TAIL
  } cntSel_t;

  typedef struct packed {
    logic    loadCnt;
    cntSel_t cntSel;
    logic    drrSet;
    logic    drrClr;
    logic    arstSet;
    logic    arstClr;
    logic    gateOff;
    logic    gateOn;
    logic    polHold;
  } seqStrobe_t;

endpackage

// File: rtl/convSeqCtrl.sv
module convSeqCtrl
  import convSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       modeSync,
  input  logic       cntZero,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done,
  output logic       syncLat
);

  seqState_t state;
  seqState_t nextState;
  logic      accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    stb       = '0;
    nextState = state;
    stb.polHold = !(state == ST_IDLE || state == ST_DONE);
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          stb.loadCnt = 1'b1;
          if (modeSync) begin
            stb.cntSel = LD_WARM;
            nextState  = ST_WARM;
          end else begin
            stb.cntSel = LD_LEAD;
            stb.drrSet = 1'b1;
            nextState  = ST_LEAD;
          end
        end
      end
      ST_WARM: begin
        if (cntZero) begin
          stb.gateOff = 1'b1;
          nextState   = ST_STOP;
        end
      end
      ST_STOP: begin
        stb.drrSet  = 1'b1;
        stb.loadCnt = 1'b1;
        stb.cntSel  = LD_LEAD;
        nextState   = ST_LEAD;
      end
      ST_LEAD: begin
        if (cntZero) begin
          stb.arstSet = 1'b1;
          stb.loadCnt = 1'b1;
          stb.cntSel  = LD_PULSE;
          nextState   = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (cntZero) begin
          stb.arstClr = 1'b1;
          stb.loadCnt = 1'b1;
          stb.cntSel  = LD_TAIL;
          nextState   = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (cntZero) begin
          stb.drrClr = 1'b1;
          stb.gateOn = 1'b1;
          nextState  = ST_SETTLE;
        end
      end
      ST_SETTLE: nextState = ST_DONE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      syncLat <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        syncLat <= modeSync;
      end else if (state == ST_SETTLE) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/convSeqDatapath.sv
module convSeqDatapath
  import convSeqPkg::*;
#(
  parameter int WARM_CYC  = 6,
  parameter int LEAD_CYC  = 2,
  parameter int ARST_CYC  = 3,
  parameter int TAIL_CYC  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t stb,
  input  logic       polIn,
  output logic       cntZero,
  output logic       drrAct,
  output logic       demuxRst,
  output logic       serialRst,
  output logic       clkEn,
  output logic       drrOut
);

  localparam int MAX_AB  = (WARM_CYC > LEAD_CYC) ? WARM_CYC : LEAD_CYC;
  localparam int MAX_CD  = (ARST_CYC > TAIL_CYC) ? ARST_CYC : TAIL_CYC;
  localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             gateReq;
  logic             polReg;

  always_comb begin
    unique case (stb.cntSel)
      LD_WARM:  loadVal = CNT_W'(WARM_CYC - 1);
      LD_LEAD:  loadVal = CNT_W'(LEAD_CYC - 1);
      LD_PULSE: loadVal = CNT_W'(ARST_CYC - 1);
      default:  loadVal = CNT_W'(TAIL_CYC - 1);
    endcase
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      drrAct    <= 1'b0;
      serialRst <= 1'b0;
      demuxRst  <= 1'b0;
      gateReq   <= 1'b1;
      polReg    <= 1'b1;
    end else begin
      if (stb.loadCnt)     cnt <= loadVal;
      else if (!cntZero)   cnt <= cnt - 1'b1;

      if (stb.drrSet) begin
        drrAct    <= 1'b1;
        serialRst <= 1'b1;
      end else if (stb.drrClr) begin
        drrAct    <= 1'b0;
        serialRst <= 1'b0;
      end

      if (stb.arstSet)      demuxRst <= 1'b1;
      else if (stb.arstClr) demuxRst <= 1'b0;

      if (stb.gateOff)      gateReq <= 1'b0;
      else if (stb.gateOn)  gateReq <= 1'b1;

      if (!stb.polHold)     polReg <= polIn;
    end
  end

  // gate enable moves on the falling edge, while the gated clock sits low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) clkEn <= 1'b1;
    else       clkEn <= gateReq;
  end

  assign drrOut = polReg ? drrAct : ~drrAct;

endmodule

// File: rtl/convResetSeq.sv
module convResetSeq
  import convSeqPkg::*;
#(
  parameter int WARM_CYC    = 6,
  parameter int LEAD_CYC    = 2,
  parameter int ARST_CYC    = 3,
  parameter int DRR_MIN_CYC = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic modeSync,
  input  logic drrActHigh,
  output logic drrOut,
  output logic demuxRst,
  output logic serialRst,
  output logic clkEn,
  output logic busy,
  output logic done
);

  localparam int TAIL_RAW = DRR_MIN_CYC - LEAD_CYC - ARST_CYC;
  localparam int TAIL_CYC = (TAIL_RAW >= 1) ? TAIL_RAW : 1;

  seqStrobe_t stb;
  logic       cntZero;
  logic       drrAct;
  logic       syncLat;

  convSeqCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .modeSync(modeSync),
    .cntZero (cntZero),
    .stb     (stb),
    .busy    (busy),
    .done    (done),
    .syncLat (syncLat)
  );

  convSeqDatapath #(
    .WARM_CYC(WARM_CYC),
    .LEAD_CYC(LEAD_CYC),
    .ARST_CYC(ARST_CYC),
    .TAIL_CYC(TAIL_CYC)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .polIn    (drrActHigh),
    .cntZero  (cntZero),
    .drrAct   (drrAct),
    .demuxRst (demuxRst),
    .serialRst(serialRst),
    .clkEn    (clkEn),
    .drrOut   (drrOut)
  );

endmodule

// File: rtl/convSeqChecker.sv
module convSeqChecker #(
  parameter int ARST_CYC    = 3,
  parameter int DRR_MIN_CYC = 8
) (
  input logic clk,
  input logic rstN,
  input logic drrAct,
  input logic demuxRst,
  input logic serialRst,
  input logic clkEn,
  input logic busy,
  input logic done,
  input logic syncLat
);

  logic [15:0] drrRun;
  logic [15:0] arstRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drrRun  <= '0;
      arstRun <= '0;
    end else begin
      drrRun  <= drrAct   ? ((drrRun  == 16'hFFFF) ? drrRun  : drrRun  + 1'b1) : '0;
      arstRun <= demuxRst ? ((arstRun == 16'hFFFF) ? arstRun : arstRun + 1'b1) : '0;
    end
  end

  assert_arst_in_drr_R3: assert property (@(posedge clk) disable iff (!rstN)
    demuxRst |-> drrAct);

  assert_arst_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(demuxRst) |-> $past(drrAct));

  assert_drr_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drrAct) |-> $past(!demuxRst));

  assert_drr_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drrAct) |-> (drrRun >= 16'(DRR_MIN_CYC)));

  assert_arst_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(demuxRst) |-> (arstRun == 16'(ARST_CYC)));

  assert_serial_track_R6: assert property (@(posedge clk) disable iff (!rstN)
    serialRst == drrAct);

  assert_busy_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_free_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    !syncLat |-> clkEn);

  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (syncLat && drrAct) |-> !clkEn);

  assert_done_clean_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!drrAct && !demuxRst && clkEn));

endmodule

bind convResetSeq convSeqChecker #(
  .ARST_CYC   (ARST_CYC),
  .DRR_MIN_CYC(DRR_MIN_CYC)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .drrAct   (drrAct),
  .demuxRst (demuxRst),
  .serialRst(serialRst),
  .clkEn    (clkEn),
  .busy     (busy),
  .done     (done),
  .syncLat  (syncLat)
);

// File: tb/sim_convResetSeq.sv
`timescale 1ns/1ps
module sim_convResetSeq;

  localparam int WARM = 6;
  localparam int LEAD = 2;
  localparam int ARST = 3;
  localparam int DMIN = 8;
  localparam int TAIL = (DMIN - LEAD - ARST >= 1) ? (DMIN - LEAD - ARST) : 1;
  localparam int DLEN = LEAD + ARST + TAIL;

  typedef struct packed {
    logic drr;
    logic arst;
    logic srst;
    logic ce;
    logic bsy;
    logic dn;
  } vec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic modeSync = 1'b0;
  logic drrActHigh = 1'b1;
  logic drrOut, demuxRst, serialRst, clkEn, busy, done;

  int   nVec = 0;
  int   nErr = 0;
  logic haveLast = 1'b0;
  logic lastCe = 1'b1;
  logic finished = 1'b0;
  vec_t expQ[$];

  always #10 clk = ~clk;

  convResetSeq #(
    .WARM_CYC(WARM), .LEAD_CYC(LEAD), .ARST_CYC(ARST), .DRR_MIN_CYC(DMIN)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .modeSync(modeSync),
    .drrActHigh(drrActHigh), .drrOut(drrOut), .demuxRst(demuxRst),
    .serialRst(serialRst), .clkEn(clkEn), .busy(busy), .done(done)
  );

  task automatic compare(input vec_t e, input string tag);
    logic bad;
    bad = 1'b0;
    nVec++;
    if (drrOut !== e.drr)      begin bad = 1'b1; $display("FAIL R5 %s drrOut got %b exp %b", tag, drrOut, e.drr); end
    if (demuxRst !== e.arst)   begin bad = 1'b1; $display("FAIL R3 %s demuxRst got %b exp %b", tag, demuxRst, e.arst); end
    if (serialRst !== e.srst)  begin bad = 1'b1; $display("FAIL R6 %s serialRst got %b exp %b", tag, serialRst, e.srst); end
    if (clkEn !== e.ce)        begin bad = 1'b1; $display("FAIL R8 %s clkEn got %b exp %b", tag, clkEn, e.ce); end
    if (busy !== e.bsy)        begin bad = 1'b1; $display("FAIL R2 %s busy got %b exp %b", tag, busy, e.bsy); end
    if (done !== e.dn)         begin bad = 1'b1; $display("FAIL R10 %s done got %b exp %b", tag, done, e.dn); end
    if (bad) nErr++;
  endtask

  // monitor: R9 check after the rising edge, scoreboard pop after the falling edge
  always @(posedge clk) begin
    #5;
    if (haveLast) begin
      nVec++;
      if (clkEn !== lastCe) begin
        nErr++;
        $display("FAIL R9 clkEn moved on rising edge got %b exp %b", clkEn, lastCe);
      end
    end
    #10;
    lastCe = clkEn;
    if (expQ.size() > 0) compare(expQ.pop_front(), "scoreboard");
  end

  // one run; cycle k counts from the edge that accepts start (R7, R8, R11)
  task automatic runSeq(input logic m, input logic p, input int glitchK, input int tail);
    int   off;
    int   len;
    vec_t e;
    off = m ? (WARM + 1) : 0;
    len = off + DLEN + 1 + tail;
    @(posedge clk); #5;
    start = 1'b1; modeSync = m; drrActHigh = p;
    #11;
    for (int k = 0; k < len; k++) begin
      logic act;
      act    = (k >= off) && (k < off + DLEN);
      e.drr  = p ? act : ~act;
      e.arst = (k >= off + LEAD) && (k < off + LEAD + ARST);
      e.srst = act;
      e.ce   = m ? !((k >= WARM) && (k < off + DLEN)) : 1'b1;
      e.bsy  = (k < off + DLEN + 1);
      e.dn   = (k >= off + DLEN + 1);
      expQ.push_back(e);
    end
    @(posedge clk); #5;
    start = 1'b0;
    for (int k = 1; k < len; k++) begin
      @(posedge clk); #5;
      if (k == glitchK) begin
        start = 1'b1; modeSync = ~m; drrActHigh = ~p;   // R11 ignored while busy
      end else if (k == glitchK + 1) begin
        start = 1'b0; modeSync = m; drrActHigh = p;
      end
    end
    #11;
  endtask

  // idle polarity follow, R5
  task automatic idlePol(input logic q, input logic dnExp);
    vec_t e;
    @(posedge clk); #5;
    drrActHigh = q;
    #11;
    for (int k = 0; k < 2; k++) begin
      e.drr = ~q; e.arst = 1'b0; e.srst = 1'b0; e.ce = 1'b1;
      e.bsy = 1'b0; e.dn = dnExp;
      expQ.push_back(e);
    end
    repeat (2) @(posedge clk);
    #16;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
      $finish;
    end
  endtask

  initial begin
    vec_t e;
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    repeat (2) @(posedge clk);
    #15;
    // R1 reset state
    e.drr = 1'b0; e.arst = 1'b0; e.srst = 1'b0; e.ce = 1'b1; e.bsy = 1'b0; e.dn = 1'b0;
    compare(e, "R1 reset");
    haveLast = 1'b1;
    idlePol(1'b0, 1'b0);              // R5 idle, active-low level
    runSeq(1'b0, 1'b1, -1, 3);        // R7 free-running, active high
    runSeq(1'b1, 1'b0, -1, 3);        // R8 synchronised, active low
    runSeq(1'b0, 1'b0, 4, 2);         // R11 disturbance during free-running run
    runSeq(1'b1, 1'b1, 10, 2);        // R11 disturbance during synchronised run
    idlePol(1'b1, 1'b1);              // R5 idle follow after done
    runSeq(1'b1, 1'b1, -1, 2);        // R2 restart from done
    finishRun();
  end

  initial begin
    #(20 * 100000);
    nErr++;
    $display("FAIL watchdog expired got running exp finished");
    finishRun();
  end

endmodule